// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block is one direction of a 36-bit buffer whose producer and consumer run on unrelated clocks. Words go in on the write clock and come out on the read clock in arrival order. The memory holds 1024 words. Write and read pointers cross between the domains as Gray code through two-stage synchronizers.

A level sampled during reset picks one of two presentation modes. In standard mode a word reaches the output register only when a read is issued. In fall-through mode the oldest word is loaded into the output register on its own, and each read replaces it with the next word. The same read-side status pin changes meaning with the mode: in standard mode it is an active-low empty flag, and in fall-through mode it is an output-valid flag.

The write side reports whether it can take a word. It also reports almost-full, measured against a free-space offset. The read side reports almost-empty, measured against a stored-word offset. Both offsets come from a neighbouring configuration block. In standard mode an active-low strobe rewinds the read pointer to location zero, so the stored data can be read out again.

Top module: `xclk_fifo`

## Requirements
- R1: While `rst_n` is low, `rd_rdy_o` and `rd_aempty_n_o` are low, `wr_rdy_o` is low and `wr_afull_n_o` is high. After reset the buffer is empty, with both pointers at location zero.
- R2: The read-clock value of `mode_std_i` during reset picks the mode: 1 selects standard mode and 0 selects fall-through mode. The input must not change after reset.
- R3: A port transfers a word on a rising edge of its clock only when its enable is 1 and its chip select (active low) is 0. Otherwise stored data and the output register are left unchanged.
- R4: In standard mode, a written word does not reach `rd_data_o` until a read is issued. `rd_rdy_o` is 1 exactly when the memory holds at least one word.
- R5: In fall-through mode, the oldest word appears on `rd_data_o` without a read and `rd_rdy_o` goes to 1. A read then replaces it with the next word, or drops `rd_rdy_o` to 0 if no word follows.
- R6: `wr_rdy_o` is 0 while the memory holds 1024 words. A write attempted then is discarded.
- R7: `rd_aempty_n_o` is 0 when the stored word count is less than or equal to `ae_offset_i`, and 1 otherwise.
- R8: `wr_afull_n_o` is 0 when the free location count is less than or equal to `af_offset_i`, and 1 otherwise.
- R9: In standard mode, a 0 on `rt_n_i` at a read-clock edge sets the read pointer to location zero. This takes precedence over a read in the same cycle, and all words written since reset can then be read again.
- R10: In fall-through mode `rt_n_i` has no effect.
- R11: Words leave in the order they were written, across the two clock domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_std_i | input | 1 | Mode select, sampled during reset: 1 = standard, 0 = fall-through |
| wr_cs_n_i | input | 1 | Write port select, active low |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | 36 | Write data |
| af_offset_i | input | 11 | Almost-full free-space offset |
| wr_rdy_o | output | 1 | Standard mode: not full. Fall-through mode: space available |
| wr_afull_n_o | output | 1 | Almost-full flag, active low |
| rd_cs_n_i | input | 1 | Read port select, active low |
| rd_en_i | input | 1 | Read enable |
| rt_n_i | input | 1 | Retransmit strobe, active low |
| ae_offset_i | input | 11 | Almost-empty stored-count offset |
| rd_data_o | output | 36 | Read data register |
| rd_rdy_o | output | 1 | Standard mode: not empty. Fall-through mode: output valid |
| rd_aempty_n_o | output | 1 | Almost-empty flag, active low |

## Verification
A read pointer that advances wrongly shows up as a wrong word on `rd_data_o` at the very next read. A wrong retransmit rewind appears the same way, on the first read after the strobe. A wrong pointer difference shifts the empty, full or almost thresholds by whole words. The bench walks the fill level across each boundary and checks the flags after the synchronizer latency has settled, which is a few read or write clocks. A fall-through register that fails to load, or that loads twice, is visible as a stale or skipped head word as soon as the crossing completes.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {
    MODE_FALL = 1'b0,
    MODE_STD  = 1'b1
  } fifo_mode_e;

  // binary to reflected Gray code
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // distance from lag to lead, modulo 2**pw
  function automatic logic [31:0] span(input logic [31:0] lead,
                                       input logic [31:0] lag,
                                       input int unsigned pw);
    logic [31:0] m;
    m = (32'd1 << pw) - 32'd1;
    return (lead - lag) & m;
  endfunction

endpackage

// File: rtl/dcf_reset_sync.sv
module dcf_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  // assertion follows the raw input at once, release waits for the chain
  assign rst_n_o = q[STAGES-1] & arst_n;
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 36,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // captured by the read-side output register
  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic        wclk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [AW:0] rgray_s,
  input  logic [AW:0] af_lim,
  output logic [AW:0] wptr,
  output logic [AW:0] wgray,
  output logic        fire_o,
  output logic        full_o,
  output logic        rdy_o,
  output logic        af_n_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0] rbin_s, used, free, wptr_nx;

  always_comb begin
    rbin_s  = PW'(from_gray(32'(rgray_s)));
    used    = PW'(span(32'(wptr), 32'(rbin_s), PW));
    free    = DEPTH_P - used;
    wptr_nx = wptr + PW'(1);
  end

  assign full_o = (used == DEPTH_P);
  assign fire_o = req && !full_o;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (fire_o) begin
      wptr  <= wptr_nx;
      wgray <= PW'(to_gray(32'(wptr_nx)));
    end
  end

  assign rdy_o  = rst_n && !full_o;
  assign af_n_o = !rst_n || (free > af_lim);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 10
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          mode_std,
  input  logic          req,
  input  logic          rt_n,
  input  logic [AW:0]   wgray_s,
  input  logic [AW:0]   ae_lim,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rptr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] data_o,
  output logic          rdy_o,
  output logic          ae_n_o,
  output logic          fire_o,
  output logic          pop_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_s, mem_cnt, stored, rptr_nx;
  logic          ov, mem_empty, rt_hit;

  always_comb begin
    wbin_s    = PW'(from_gray(32'(wgray_s)));
    mem_cnt   = PW'(span(32'(wbin_s), 32'(rptr), PW));
    mem_empty = (mem_cnt == '0);
    rt_hit    = mode_std && !rt_n;
    if (mode_std) begin
      fire_o = req && !mem_empty && !rt_hit;
      pop_o  = fire_o;
    end else begin
      fire_o = req && ov;
      pop_o  = !mem_empty && (!ov || fire_o);
    end
    rptr_nx = rptr + PW'(1);
    stored  = mem_cnt + PW'(ov);
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      data_o <= '0;
      ov     <= 1'b0;
    end else begin
      if (rt_hit) begin
        rptr  <= '0;
        rgray <= '0;
      end else if (pop_o) begin
        rptr  <= rptr_nx;
        rgray <= PW'(to_gray(32'(rptr_nx)));
      end
      if (pop_o) data_o <= mem_q;
      if (mode_std)    ov <= 1'b0;
      else if (pop_o)  ov <= 1'b1;
      else if (fire_o) ov <= 1'b0;
    end
  end

  assign raddr  = rptr[AW-1:0];
  assign rdy_o  = rst_n && (mode_std ? !mem_empty : ov);
  assign ae_n_o = rst_n && (stored > ae_lim);
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import dcf_pkg::*;
#(
  parameter int DW          = 36,
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          mode_std_i,
  input  logic          wr_cs_n_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW:0]   af_offset_i,
  output logic          wr_rdy_o,
  output logic          wr_afull_n_o,
  input  logic          rd_cs_n_i,
  input  logic          rd_en_i,
  input  logic          rt_n_i,
  input  logic [AW:0]   ae_offset_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_rdy_o,
  output logic          rd_aempty_n_o
);
  localparam int PW = AW + 1;

  logic          rst_w_n, rst_r_n;
  fifo_mode_e    mode_q;
  logic          mode_std_r;
  logic          wr_req, rd_req, wr_fire, wr_full, rd_fire, rd_pop;
  logic [PW-1:0] wptr_bin, wgray, wgray_s, rptr_bin, rgray, rgray_s;
  logic [AW-1:0] raddr;
  logic [DW-1:0] mem_q;

  dcf_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_w (
    .clk(wclk), .arst_n(rst_n), .rst_n_o(rst_w_n));
  dcf_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_r (
    .clk(rclk), .arst_n(rst_n), .rst_n_o(rst_r_n));

  // mode follows the pin only while the read domain is held in reset
  always_ff @(posedge rclk) begin
    if (!rst_r_n) mode_q <= fifo_mode_e'(mode_std_i);
  end
  assign mode_std_r = (mode_q == MODE_STD);

  assign wr_req = wr_en_i && !wr_cs_n_i;
  assign rd_req = rd_en_i && !rd_cs_n_i;

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_w_n), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_r_n), .d(wgray), .q(wgray_s));

  dcf_wr_side #(.AW(AW)) u_wr (
    .wclk(wclk), .rst_n(rst_w_n), .req(wr_req), .rgray_s(rgray_s),
    .af_lim(af_offset_i), .wptr(wptr_bin), .wgray(wgray), .fire_o(wr_fire),
    .full_o(wr_full), .rdy_o(wr_rdy_o), .af_n_o(wr_afull_n_o));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data_i),
    .raddr(raddr), .rdata(mem_q));

  dcf_rd_side #(.DW(DW), .AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_r_n), .mode_std(mode_std_r), .req(rd_req),
    .rt_n(rt_n_i), .wgray_s(wgray_s), .ae_lim(ae_offset_i), .mem_q(mem_q),
    .raddr(raddr), .rptr(rptr_bin), .rgray(rgray), .data_o(rd_data_o),
    .rdy_o(rd_rdy_o), .ae_n_o(rd_aempty_n_o), .fire_o(rd_fire), .pop_o(rd_pop));
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int DW = 36,
  parameter int AW = 10
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_req,
  input logic          wr_full,
  input logic [AW:0]   wptr,
  input logic          wr_rdy,
  input logic          af_n,
  input logic          mode_std,
  input logic          rd_fire,
  input logic          rd_pop,
  input logic          rt_n,
  input logic [AW:0]   rptr,
  input logic [DW-1:0] rd_data,
  input logic          rd_rdy,
  input logic          ae_n
);
  // R1: read-side flags low while reset is held
  assert_rst_rflags_R1: assert property (@(posedge rclk)
    !rst_n |-> (!rd_rdy && !ae_n));

  // R1: write-side flags in their reset levels
  assert_rst_wflags_R1: assert property (@(posedge wclk)
    !rst_n |-> (!wr_rdy && af_n));

  // R3: no request, no write pointer movement
  assert_idle_write_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_req |=> $stable(wptr));

  // R6: a write into a full memory is dropped
  assert_no_overflow_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_req && wr_full) |=> $stable(wptr));

  // R4: standard mode output register changes only on a read
  assert_std_hold_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode_std && !rd_fire) |=> $stable(rd_data));

  // R5: a presented head word stays until it is read
  assert_fall_hold_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    (!mode_std && rd_rdy && !rd_fire) |=> (rd_rdy && $stable(rd_data)));

  // R9: retransmit strobe rewinds to location zero
  assert_rewind_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode_std && !rt_n) |=> (rptr == '0));

  // R10: strobe leaves the read pointer alone in fall-through mode
  assert_rt_ignored_R10: assert property (@(posedge rclk) disable iff (!rst_n)
    (!mode_std && !rt_n && !rd_pop) |=> $stable(rptr));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_req(wr_req), .wr_full(wr_full),
  .wptr(wptr_bin), .wr_rdy(wr_rdy_o), .af_n(wr_afull_n_o), .mode_std(mode_std_r),
  .rd_fire(rd_fire), .rd_pop(rd_pop), .rt_n(rt_n_i), .rptr(rptr_bin),
  .rd_data(rd_data_o), .rd_rdy(rd_rdy_o), .ae_n(rd_aempty_n_o));

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
  logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic        mode_std_i = 1'b1;
  logic        wr_cs_n_i = 1'b0, wr_en_i = 1'b0;
  logic [35:0] wr_data_i = '0;
  logic [10:0] af_offset_i = 11'd4, ae_offset_i = 11'd4;
  logic        rd_cs_n_i = 1'b0, rd_en_i = 1'b0, rt_n_i = 1'b1;
  logic        wr_rdy_o, wr_afull_n_o, rd_rdy_o, rd_aempty_n_o;
  logic [35:0] rd_data_o;
  int          n_chk = 0, n_err = 0;

  always #10 wclk = ~wclk;
  initial begin
    #7;
    forever #10 rclk = ~rclk;
  end

  xclk_fifo u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .mode_std_i(mode_std_i),
    .wr_cs_n_i(wr_cs_n_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .af_offset_i(af_offset_i), .wr_rdy_o(wr_rdy_o), .wr_afull_n_o(wr_afull_n_o),
    .rd_cs_n_i(rd_cs_n_i), .rd_en_i(rd_en_i), .rt_n_i(rt_n_i),
    .ae_offset_i(ae_offset_i), .rd_data_o(rd_data_o), .rd_rdy_o(rd_rdy_o),
    .rd_aempty_n_o(rd_aempty_n_o));

  // fill level, then expected {rd_rdy, aempty_n, wr_rdy, afull_n}; offsets 4 and 4
  localparam logic [15:0] VEC [8] = '{
    {12'd0,    4'b0011}, {12'd1,    4'b1011}, {12'd4,    4'b1011},
    {12'd5,    4'b1111}, {12'd1019, 4'b1111}, {12'd1020, 4'b1110},
    {12'd1023, 4'b1110}, {12'd1024, 4'b1100}};

  task automatic chk(input string rq, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  task automatic do_reset(input logic std);
    @(negedge wclk);
    rst_n = 1'b0; mode_std_i = std;
    wr_en_i = 1'b0; rd_en_i = 1'b0; rt_n_i = 1'b1;
    wr_cs_n_i = 1'b0; rd_cs_n_i = 1'b0;
    repeat (6) @(negedge wclk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic push_burst(input int n, input int base, input logic cs_n);
    @(negedge wclk);
    wr_cs_n_i = cs_n; wr_en_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      wr_data_i = 36'(base) + 36'(i);
      @(negedge wclk);
    end
    wr_en_i = 1'b0; wr_cs_n_i = 1'b0;
  endtask

  task automatic pop(input logic cs_n, output logic [35:0] got);
    @(negedge rclk);
    rd_cs_n_i = cs_n; rd_en_i = 1'b1;
    @(negedge rclk);
    rd_en_i = 1'b0; rd_cs_n_i = 1'b0;
    got = rd_data_o;
  endtask

  task automatic pulse_rt();
    @(negedge rclk);
    rt_n_i = 1'b0;
    @(negedge rclk);
    rt_n_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    n_err++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [35:0] got;
    // R1: levels while reset is held
    repeat (4) @(negedge rclk);
    chk("R1 rd_rdy", 36'(rd_rdy_o), 36'd0);
    chk("R1 aempty_n", 36'(rd_aempty_n_o), 36'd0);
    chk("R1 wr_rdy", 36'(wr_rdy_o), 36'd0);
    chk("R1 afull_n", 36'(wr_afull_n_o), 36'd1);

    // flag table over fill levels, standard mode
    for (int v = 0; v < 8; v++) begin
      int n;
      n = int'(VEC[v][15:4]);
      do_reset(1'b1);
      if (n > 0) push_burst(n, 0, 1'b0);
      settle();
      chk("R4 rd_rdy fill", 36'(rd_rdy_o), 36'(VEC[v][3]));
      chk("R7 aempty_n fill", 36'(rd_aempty_n_o), 36'(VEC[v][2]));
      chk("R6 wr_rdy fill", 36'(wr_rdy_o), 36'(VEC[v][1]));
      chk("R8 afull_n fill", 36'(wr_afull_n_o), 36'(VEC[v][0]));
      if (n == 1024) begin
        push_burst(1, 36'hABC, 1'b0);   // R6: dropped write
        settle();
        @(negedge rclk);
        rd_en_i = 1'b1;
        for (int i = 0; i < 1024; i++) begin
          @(negedge rclk);
          if (i == 1023) rd_en_i = 1'b0;
          chk("R11 drain order", rd_data_o, 36'(i));
        end
        settle();
        chk("R6 overflow word dropped", 36'(rd_rdy_o), 36'd0);
      end
    end

    // R4 standard: no data until read; R2 mode high
    do_reset(1'b1);
    push_burst(1, 36'h1234, 1'b0);
    settle();
    chk("R4 no fall-through", rd_data_o, 36'd0);
    chk("R2 std ready", 36'(rd_rdy_o), 36'd1);
    pop(1'b0, got);
    chk("R4 read word", got, 36'h1234);
    settle();
    chk("R4 empty after read", 36'(rd_rdy_o), 36'd0);

    // R3: deselected ports do nothing
    push_burst(1, 36'h777, 1'b1);
    settle();
    chk("R3 write deselected", 36'(rd_rdy_o), 36'd0);
    push_burst(1, 36'h55, 1'b0);
    settle();
    pop(1'b1, got);
    chk("R3 read deselected", got, 36'h1234);
    pop(1'b0, got);
    chk("R3 read selected", got, 36'h55);

    // R9: retransmit in standard mode
    do_reset(1'b1);
    push_burst(3, 36'h300, 1'b0);
    settle();
    for (int i = 0; i < 3; i++) begin
      pop(1'b0, got);
      chk("R11 first pass", got, 36'h300 + 36'(i));
    end
    settle();
    chk("R9 empty before rewind", 36'(rd_rdy_o), 36'd0);
    pulse_rt();
    settle();
    chk("R9 ready after rewind", 36'(rd_rdy_o), 36'd1);
    for (int i = 0; i < 3; i++) begin
      pop(1'b0, got);
      chk("R9 replay", got, 36'h300 + 36'(i));
    end

    // R5, R2: fall-through mode
    do_reset(1'b0);
    chk("R2 fall empty", 36'(rd_rdy_o), 36'd0);
    push_burst(2, 36'h900, 1'b0);
    settle();
    chk("R5 head shown", rd_data_o, 36'h900);
    chk("R5 valid", 36'(rd_rdy_o), 36'd1);
    pop(1'b0, got);
    chk("R5 next head", got, 36'h901);
    // R10: strobe ignored
    pulse_rt();
    settle();
    chk("R10 head kept", rd_data_o, 36'h901);
    pop(1'b0, got);
    settle();
    chk("R10 no replay", 36'(rd_rdy_o), 36'd0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule